// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking an in-memory translation tree. It first reads the entry selected by the context table pointer and the context number, then follows descriptors through up to three levels of tables. It reaches those tables through a single-word memory port that has one transaction in flight at a time. The walk can stop at level 1, 2 or 3, which maps a 16 MB, 256 KB or 4 KB page.

When the walk ends on a page entry, the walker updates that entry's referenced and modified bits in memory itself. The returned translation carries the final entry, which a separate permission block decodes, and a write-enable hint. A failed walk returns a fault type and the level it reached.

When translation is switched off, the request completes without any memory traffic. Instruction fetches in boot mode are steered into a boot ROM window.

Top module: `page_walker`

## Requirements
- R1: The first read of a walk goes to address (ctx_ptr << 4) + (ctx_num << 2), and that entry is level 0.
- R2: Entry bits 1:0 give the type (0 invalid, 1 descriptor, 2 page entry, 3 reserved). A descriptor read at level L (L<3) points to the level L+1 table at ((entry & ~3) << 4). The index added to that base is VA[31:24]*4 for level 1, VA[23:18]*4 for level 2 and VA[17:12]*4 for level 3.
- R3: A page entry at level 1, 2 or 3 gives rsp_size 2 (16 MB), 1 (256 KB) or 0 (4 KB). rsp_pa is (entry[31:8] << 12) plus VA[23:0], VA[17:0] or VA[11:0] respectively.
- R4: An invalid entry ends the walk with rsp_fault 1, and rsp_level gives the level of that entry.
- R5: rsp_fault 4 is reported, with the level reached, for any of these: a reserved entry, a read that returns mem_err (rsp_entry 0), a page entry at level 0, or a descriptor at level 3. For the other faults rsp_entry is the entry that was read.
- R6: A page entry whose referenced bit (bit 5) is clear is written back to the address it was read from. So is a write access whose modified bit (bit 6) is clear. The written value has bit 5 set, and also bit 6 when the access is a write. In every other case nothing is written, and rsp_entry is the entry as it stands after any update.
- R7: rsp_wr_ok is 1 on a successful walk only if bit 6 of the returned entry is set. It is 0 on every fault.
- R8: With xlate_off and boot_mode both high, an instruction fetch returns rsp_pa = prom_base | VA[18:0], with no memory access.
- R9: With xlate_off high, any other access returns rsp_pa = VA zero-extended, rsp_wr_ok 1, rsp_size 0, rsp_fault 0 and rsp_level 0, with no memory access.
- R10: busy is high from the cycle after a request is accepted until the response. A request made while busy is ignored and produces no response.
- R11: mem_req, mem_addr and mem_we stay stable until mem_ack, and only one memory transaction is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request strobe (taken when idle) |
| req_va | input | 32 | Virtual address |
| req_write | input | 1 | Access is a store |
| req_fetch | input | 1 | Access is an instruction fetch |
| xlate_off | input | 1 | Translation bypassed |
| boot_mode | input | 1 | Steer bypassed fetches to boot ROM |
| prom_base | input | 36 | Boot ROM base address |
| ctx_ptr | input | 32 | Context table pointer |
| ctx_num | input | CTX_W | Context number |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | Transaction is a write |
| mem_addr | output | 36 | Word address of transaction |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Transaction completes this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_err | input | 1 | Read error, valid with mem_ack |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 3 | 0 none, 1 invalid, 4 translation error |
| rsp_level | output | 2 | Level reached, 0 to 3 |
| rsp_pa | output | 36 | Physical address |
| rsp_size | output | 2 | 0 4 KB, 1 256 KB, 2 16 MB |
| rsp_entry | output | 32 | Final entry |
| rsp_wr_ok | output | 1 | Write may be granted |

## Verification
The bench aims at the endpoints of the walk: a page entry at the context level, a descriptor at the last level, a reserved entry mid-walk and a read error. A design that miscounted levels would report the wrong level, or would keep walking past level 3 instead of faulting. Write-back is checked over a series of accesses to one page: a first read, a repeat read, a write, and another read. A walker that wrote back unconditionally, or forgot the modified bit, would show the wrong write count, memory word or write hint. Requests made while a walk is running and boot-mode fetch steering are also covered; a walker that accepted the extra request would give a second response.

// File: rtl/pw_pkg.sv
package pw_pkg;
    localparam int ENT_W      = 32;
    localparam int VA_W       = 32;
    localparam int PA_W       = ENT_W + 4;
    localparam int LVL_W      = 2;
    localparam int LAST_LVL   = 3;
    localparam int REF_BIT    = 5;
    localparam int MOD_BIT    = 6;
    localparam int BOOT_OFS_W = 19;

    typedef enum logic [1:0] {
        ET_INVALID = 2'd0,
        ET_DESC    = 2'd1,
        ET_PAGE    = 2'd2,
        ET_RSVD    = 2'd3
    } ent_type_e;

    typedef enum logic [2:0] {
        FT_NONE    = 3'd0,
        FT_INVALID = 3'd1,
        FT_XLATE   = 3'd4
    } fault_e;

    typedef enum logic [1:0] {
        PS_4K   = 2'd0,
        PS_256K = 2'd1,
        PS_16M  = 2'd2
    } pg_size_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_WBACK
    } walk_state_e;

    typedef struct packed {
        fault_e              fault;
        logic [LVL_W-1:0]    level;
        logic [PA_W-1:0]     pa;
        pg_size_e            size;
        logic [ENT_W-1:0]    entry;
        logic                wr_ok;
    } walk_rsp_t;
endpackage

// File: rtl/pw_addr_calc.sv
module pw_addr_calc
    import pw_pkg::*;
#(
    parameter int CTX_W = 8
) (
    input  logic [LVL_W-1:0]  nxt_lvl,
    input  logic [31:0]       ctx_ptr,
    input  logic [CTX_W-1:0]  ctx_num,
    input  logic [ENT_W-3:0]  desc_hi,
    input  logic [VA_W-13:0]  vpn,
    output logic [PA_W-1:0]   addr
);
    logic [PA_W-1:0] tbl_base;
    logic [PA_W-1:0] tbl_idx;

    always_comb begin
        tbl_base = {desc_hi, 2'b00, 4'b0000};
        case (nxt_lvl)
            2'd1:    tbl_idx = PA_W'({vpn[19:12], 2'b00});
            2'd2:    tbl_idx = PA_W'({vpn[11:6], 2'b00});
            default: tbl_idx = PA_W'({vpn[5:0], 2'b00});
        endcase
        if (nxt_lvl == '0)
            addr = {ctx_ptr, 4'b0000} + PA_W'({ctx_num, 2'b00});
        else
            addr = tbl_base + tbl_idx;
    end
endmodule

// File: rtl/pw_entry_update.sv
module pw_entry_update
    import pw_pkg::*;
(
    input  logic [ENT_W-1:0] entry,
    input  logic             is_write,
    output logic             need_wb,
    output logic [ENT_W-1:0] new_entry
);
    always_comb begin
        need_wb   = !entry[REF_BIT] || (is_write && !entry[MOD_BIT]);
        new_entry = entry;
        new_entry[REF_BIT] = 1'b1;
        if (is_write)
            new_entry[MOD_BIT] = 1'b1;
    end
endmodule

// File: rtl/pw_result_calc.sv
module pw_result_calc
    import pw_pkg::*;
(
    input  logic [ENT_W-9:0]  ppn,
    input  logic [23:0]       va_lo,
    input  logic [LVL_W-1:0]  lvl,
    output logic [PA_W-1:0]   pa,
    output pg_size_e          size
);
    logic [23:0] ofs;

    always_comb begin
        case (lvl)
            2'd1: begin ofs = va_lo;                 size = PS_16M;  end
            2'd2: begin ofs = {6'b0, va_lo[17:0]};   size = PS_256K; end
            2'd3: begin ofs = {12'b0, va_lo[11:0]};  size = PS_4K;   end
            default: begin ofs = '0;                 size = PS_4K;   end
        endcase
        pa = {ppn, 12'b0} + PA_W'(ofs);
    end
endmodule

// File: rtl/page_walker.sv
module page_walker
    import pw_pkg::*;
#(
    parameter int CTX_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_va,
    input  logic              req_write,
    input  logic              req_fetch,
    input  logic              xlate_off,
    input  logic              boot_mode,
    input  logic [PA_W-1:0]   prom_base,
    input  logic [31:0]       ctx_ptr,
    input  logic [CTX_W-1:0]  ctx_num,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [PA_W-1:0]   mem_addr,
    output logic [ENT_W-1:0]  mem_wdata,
    input  logic              mem_ack,
    input  logic [ENT_W-1:0]  mem_rdata,
    input  logic              mem_err,
    output logic              rsp_valid,
    output logic [2:0]        rsp_fault,
    output logic [LVL_W-1:0]  rsp_level,
    output logic [PA_W-1:0]   rsp_pa,
    output logic [1:0]        rsp_size,
    output logic [ENT_W-1:0]  rsp_entry,
    output logic              rsp_wr_ok
);
    walk_state_e       state_q;
    logic [VA_W-1:0]   va_q;
    logic              wr_q;
    logic [LVL_W-1:0]  lvl_q;
    logic [ENT_W-1:0]  ent_q;
    walk_rsp_t         rsp_q;

    logic [LVL_W-1:0]  nxt_lvl;
    logic [PA_W-1:0]   nxt_addr;
    logic              need_wb;
    logic [ENT_W-1:0]  upd_entry;
    logic [ENT_W-1:0]  fin_entry;
    logic [PA_W-1:0]   fin_pa;
    pg_size_e          fin_size;
    ent_type_e         rd_type;
    walk_rsp_t         byp_rsp;
    walk_rsp_t         ok_rsp;

    assign nxt_lvl   = (state_q == ST_IDLE) ? '0 : lvl_q + 1'b1;
    assign rd_type   = ent_type_e'(mem_rdata[1:0]);
    assign fin_entry = (state_q == ST_WBACK) ? ent_q : mem_rdata;

    pw_addr_calc #(.CTX_W(CTX_W)) u_addr (
        .nxt_lvl (nxt_lvl),
        .ctx_ptr (ctx_ptr),
        .ctx_num (ctx_num),
        .desc_hi (mem_rdata[ENT_W-1:2]),
        .vpn     (va_q[VA_W-1:12]),
        .addr    (nxt_addr)
    );

    pw_entry_update u_upd (
        .entry     (mem_rdata),
        .is_write  (wr_q),
        .need_wb   (need_wb),
        .new_entry (upd_entry)
    );

    pw_result_calc u_res (
        .ppn   (fin_entry[ENT_W-1:8]),
        .va_lo (va_q[23:0]),
        .lvl   (lvl_q),
        .pa    (fin_pa),
        .size  (fin_size)
    );

    always_comb begin
        byp_rsp       = '0;
        byp_rsp.fault = FT_NONE;
        byp_rsp.size  = PS_4K;
        byp_rsp.wr_ok = 1'b1;
        if (req_fetch && boot_mode)
            byp_rsp.pa = prom_base | PA_W'(req_va[BOOT_OFS_W-1:0]);
        else
            byp_rsp.pa = PA_W'(req_va);

        ok_rsp        = '0;
        ok_rsp.fault  = FT_NONE;
        ok_rsp.level  = lvl_q;
        ok_rsp.pa     = fin_pa;
        ok_rsp.size   = fin_size;
        ok_rsp.entry  = fin_entry;
        ok_rsp.wr_ok  = fin_entry[MOD_BIT];
    end

    function automatic walk_rsp_t fault_rsp(input fault_e ft, input logic [LVL_W-1:0] lv,
                                            input logic [ENT_W-1:0] ent);
        walk_rsp_t r;
        r       = '0;
        r.fault = ft;
        r.level = lv;
        r.size  = PS_4K;
        r.entry = ent;
        return r;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            va_q      <= '0;
            wr_q      <= 1'b0;
            lvl_q     <= '0;
            ent_q     <= '0;
            mem_req   <= 1'b0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            rsp_valid <= 1'b0;
            rsp_q     <= '0;
        end else begin
            rsp_valid <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (xlate_off) begin
                            rsp_q     <= byp_rsp;
                            rsp_valid <= 1'b1;
                        end else begin
                            va_q     <= req_va;
                            wr_q     <= req_write;
                            lvl_q    <= '0;
                            mem_addr <= nxt_addr;
                            mem_we   <= 1'b0;
                            mem_req  <= 1'b1;
                            state_q  <= ST_READ;
                        end
                    end
                end
                ST_READ: begin
                    if (mem_ack) begin
                        if (mem_err) begin
                            rsp_q <= fault_rsp(FT_XLATE, lvl_q, '0);
                            rsp_valid <= 1'b1;
                            mem_req   <= 1'b0;
                            state_q   <= ST_IDLE;
                        end else begin
                            case (rd_type)
                                ET_DESC: begin
                                    if (lvl_q == LVL_W'(LAST_LVL)) begin
                                        rsp_q     <= fault_rsp(FT_XLATE, lvl_q, mem_rdata);
                                        rsp_valid <= 1'b1;
                                        mem_req   <= 1'b0;
                                        state_q   <= ST_IDLE;
                                    end else begin
                                        lvl_q    <= nxt_lvl;
                                        mem_addr <= nxt_addr;
                                    end
                                end
                                ET_PAGE: begin
                                    if (lvl_q == '0) begin
                                        rsp_q     <= fault_rsp(FT_XLATE, lvl_q, mem_rdata);
                                        rsp_valid <= 1'b1;
                                        mem_req   <= 1'b0;
                                        state_q   <= ST_IDLE;
                                    end else if (need_wb) begin
                                        ent_q     <= upd_entry;
                                        mem_wdata <= upd_entry;
                                        mem_we    <= 1'b1;
                                        state_q   <= ST_WBACK;
                                    end else begin
                                        rsp_q     <= ok_rsp;
                                        rsp_valid <= 1'b1;
                                        mem_req   <= 1'b0;
                                        state_q   <= ST_IDLE;
                                    end
                                end
                                ET_INVALID: begin
                                    rsp_q     <= fault_rsp(FT_INVALID, lvl_q, mem_rdata);
                                    rsp_valid <= 1'b1;
                                    mem_req   <= 1'b0;
                                    state_q   <= ST_IDLE;
                                end
                                default: begin
                                    rsp_q     <= fault_rsp(FT_XLATE, lvl_q, mem_rdata);
                                    rsp_valid <= 1'b1;
                                    mem_req   <= 1'b0;
                                    state_q   <= ST_IDLE;
                                end
                            endcase
                        end
                    end
                end
                ST_WBACK: begin
                    if (mem_ack) begin
                        rsp_q     <= ok_rsp;
                        rsp_valid <= 1'b1;
                        mem_req   <= 1'b0;
                        mem_we    <= 1'b0;
                        state_q   <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy      = (state_q != ST_IDLE);
    assign rsp_fault = rsp_q.fault;
    assign rsp_level = rsp_q.level;
    assign rsp_pa    = rsp_q.pa;
    assign rsp_size  = rsp_q.size;
    assign rsp_entry = rsp_q.entry;
    assign rsp_wr_ok = rsp_q.wr_ok;

    p_req_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    p_req_busy_r10: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy);

    p_rsp_idle_r10: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !busy);

    p_wb_ref_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> mem_wdata[REF_BIT]);

    p_wb_mod_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && wr_q) |-> mem_wdata[MOD_BIT]);

    p_fault_nowr_r7: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault != 3'd0) |-> !rsp_wr_ok);

    p_wb_same_addr_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we) |-> $stable(mem_addr));
endmodule

// File: tb/test_page_walker.sv
module test_page_walker;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_LAT    = 2;
    localparam int WATCHDOG   = 20000;
    localparam logic [31:0] CTX_PTR = 32'h0010_0000;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_write, req_fetch, xlate_off, boot_mode;
    logic [31:0] req_va;
    logic [35:0] prom_base;
    logic [31:0] ctx_ptr;
    logic [7:0]  ctx_num;
    logic        busy, mem_req, mem_we, mem_ack, mem_err;
    logic [35:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;
    logic        rsp_valid, rsp_wr_ok;
    logic [2:0]  rsp_fault;
    logic [1:0]  rsp_level, rsp_size;
    logic [35:0] rsp_pa;
    logic [31:0] rsp_entry;

    int checks = 0;
    int failures = 0;
    int wr_cnt = 0;
    int rsp_cnt = 0;
    logic [35:0] err_addr = '1;
    logic [31:0] mem [logic [35:0]];

    logic [2:0]  e_fault;
    logic [1:0]  e_lvl, e_size;
    logic [35:0] e_pa, e_waddr;
    logic [31:0] e_entry;
    logic        e_wr_ok;
    int          e_writes;

    always #(CLK_PERIOD/2) clk = ~clk;

    page_walker i_page_walker (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_va(req_va),
        .req_write(req_write), .req_fetch(req_fetch), .xlate_off(xlate_off),
        .boot_mode(boot_mode), .prom_base(prom_base), .ctx_ptr(ctx_ptr),
        .ctx_num(ctx_num), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .mem_err(mem_err), .rsp_valid(rsp_valid),
        .rsp_fault(rsp_fault), .rsp_level(rsp_level), .rsp_pa(rsp_pa),
        .rsp_size(rsp_size), .rsp_entry(rsp_entry), .rsp_wr_ok(rsp_wr_ok)
    );

    function automatic logic [31:0] rd(input logic [35:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    function automatic logic [35:0] tbl_base(input int n, input int l);
        return 36'h1000_0000 + 36'(n) * 36'h1_0000 + 36'(l) * 36'h1000;
    endfunction

    function automatic logic [35:0] idx_of(input int l, input logic [31:0] va);
        if (l == 1) return 36'(va[31:24]) * 4;
        if (l == 2) return 36'(va[23:18]) * 4;
        return 36'(va[17:12]) * 4;
    endfunction

    function automatic logic [31:0] pte(input logic [35:0] pbase, input int acc,
                                        input bit r, input bit m);
        return {pbase[35:12], 8'h00} | (32'(m) << 6) | (32'(r) << 5) | (32'(acc) << 2) | 32'h2;
    endfunction

    // Build a chain of descriptors from context n down to level depth, ending in leaf.
    task automatic map(input int n, input logic [31:0] va, input int depth, input logic [31:0] leaf);
        logic [35:0] a;
        a = {CTX_PTR, 4'h0} + 36'(n) * 4;
        for (int l = 0; l < depth; l++) begin
            mem[a] = 32'(tbl_base(n, l + 1) >> 4) | 32'h1;
            a = tbl_base(n, l + 1) + idx_of(l + 1, va);
        end
        mem[a] = leaf;
    endtask

    function automatic logic [35:0] entry_addr(input int n, input logic [31:0] va, input int lvl);
        logic [35:0] a;
        a = {CTX_PTR, 4'h0} + 36'(n) * 4;
        for (int l = 0; l < lvl; l++) a = tbl_base(n, l + 1) + idx_of(l + 1, va);
        return a;
    endfunction

    // Behavioural reference of the whole request.
    task automatic model(input logic [31:0] va, input bit wr, input bit fetch,
                         input bit byp, input bit boot);
        logic [35:0] a;
        logic [31:0] e;
        int lvl;
        bit done;
        e_fault = 0; e_lvl = 0; e_size = 0; e_pa = 0; e_entry = 0;
        e_wr_ok = 0; e_writes = 0; e_waddr = 0;
        if (byp) begin
            e_pa = (fetch && boot) ? (prom_base | 36'(va[18:0])) : 36'(va);
            e_wr_ok = 1;
            return;
        end
        a = {ctx_ptr, 4'h0} + 36'(ctx_num) * 4;
        lvl = 0;
        done = 0;
        while (!done) begin
            e_lvl = 2'(lvl);
            if (a == err_addr) begin e_fault = 4; e_entry = 0; return; end
            e = rd(a);
            e_entry = e;
            case (e[1:0])
                2'd0: begin e_fault = 1; return; end
                2'd3: begin e_fault = 4; return; end
                2'd1: begin
                    if (lvl == 3) begin e_fault = 4; return; end
                    lvl = lvl + 1;
                    a = ({4'h0, e[31:2], 2'b00} << 4) + idx_of(lvl, va);
                end
                default: begin
                    if (lvl == 0) begin e_fault = 4; return; end
                    done = 1;
                end
            endcase
        end
        if (!e[5] || (wr && !e[6])) begin
            e = e | 32'h20 | (wr ? 32'h40 : 32'h0);
            e_writes = 1;
            e_waddr = a;
        end
        e_entry = e;
        e_wr_ok = e[6];
        if (lvl == 1) begin e_size = 2; e_pa = {e[31:8], 12'h0} + 36'(va[23:0]); end
        else if (lvl == 2) begin e_size = 1; e_pa = {e[31:8], 12'h0} + 36'(va[17:0]); end
        else begin e_size = 0; e_pa = {e[31:8], 12'h0} + 36'(va[11:0]); end
    endtask

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic run(input logic [31:0] va, input bit wr, input bit fetch,
                       input bit byp, input bit boot, input bit intrude, input string rq);
        model(va, wr, fetch, byp, boot);
        wr_cnt = 0;
        @(negedge clk);
        req_valid = 1; req_va = va; req_write = wr; req_fetch = fetch;
        xlate_off = byp; boot_mode = boot;
        @(negedge clk);
        req_valid = 0;
        if (intrude && busy) begin
            // R10: a request made while busy must be ignored
            req_valid = 1; req_va = va ^ 32'hFFFF_F000; req_write = 1;
            @(negedge clk);
            req_valid = 0;
        end
        while (!rsp_valid) @(negedge clk);
        chk(rsp_fault == e_fault, rq, "fault", 64'(rsp_fault), 64'(e_fault));
        chk(rsp_level == e_lvl, rq, "level", 64'(rsp_level), 64'(e_lvl));
        chk(rsp_pa == e_pa, rq, "pa", 64'(rsp_pa), 64'(e_pa));
        chk(rsp_size == e_size, rq, "size", 64'(rsp_size), 64'(e_size));
        chk(rsp_entry == e_entry, rq, "entry", 64'(rsp_entry), 64'(e_entry));
        chk(rsp_wr_ok == e_wr_ok, rq, "wr_ok", 64'(rsp_wr_ok), 64'(e_wr_ok));
        chk(wr_cnt == e_writes, rq, "writes", 64'(wr_cnt), 64'(e_writes));
        if (e_writes != 0)
            chk(rd(e_waddr) == e_entry, rq, "mem_after_wb", 64'(rd(e_waddr)), 64'(e_entry));
    endtask

    // Memory responder: acks MEM_LAT cycles after a request appears.
    initial begin
        int cnt;
        cnt = 0;
        mem_ack = 0; mem_err = 0; mem_rdata = 0;
        forever begin
            @(negedge clk);
            mem_ack = 0; mem_err = 0;
            if (mem_req) begin
                if (cnt == MEM_LAT) begin
                    mem_ack = 1;
                    cnt = 0;
                    if (mem_we) begin
                        mem[mem_addr] = mem_wdata;
                        wr_cnt++;
                    end else begin
                        mem_err = (mem_addr == err_addr);
                        mem_rdata = mem_err ? 32'h0 : rd(mem_addr);
                    end
                end else begin
                    cnt++;
                end
            end else begin
                cnt = 0;
            end
        end
    end

    // Per-clock response monitor.
    initial forever begin
        @(negedge clk);
        if (rsp_valid) rsp_cnt++;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int c0;
        rst = 1; req_valid = 0; req_va = 0; req_write = 0; req_fetch = 0;
        xlate_off = 0; boot_mode = 0; prom_base = 36'h0_FFF0_0000;
        ctx_ptr = CTX_PTR; ctx_num = 0;
        repeat (3) @(negedge clk);
        chk(busy == 0 && rsp_valid == 0 && mem_req == 0, "R10", "reset_idle",
            64'({busy, rsp_valid, mem_req}), 64'h0);
        rst = 0;

        // R1 R2 R3 R6 R7: 4 KB page, first touch sets referenced only
        map(1, 32'h1234_5678, 3, pte(36'h8_ABCD_E000, 3, 0, 0));
        ctx_num = 1;
        run(32'h1234_5678, 0, 0, 0, 0, 0, "R6");
        // R6: already referenced, read leaves memory alone; R7: no write permission yet
        run(32'h1234_5678, 0, 0, 0, 0, 0, "R7");
        // R6: write sets modified
        run(32'h1234_5A78, 1, 0, 0, 0, 0, "R6");
        // R7: modified set, write permission granted
        run(32'h1234_5678, 0, 0, 0, 0, 0, "R7");

        // R3: 256 KB page at level 2, already referenced and modified
        map(2, 32'h0ABC_DEF0, 2, pte(36'h7_0000_0000, 1, 1, 1));
        ctx_num = 2;
        run(32'h0ABC_DEF0, 0, 0, 0, 0, 0, "R3");

        // R3: 16 MB page at level 1, fetch
        map(3, 32'hC0FF_EE44, 1, pte(36'h5_0000_0000, 2, 0, 0));
        ctx_num = 3;
        run(32'hC0FF_EE44, 0, 1, 0, 0, 0, "R3");

        // R4: invalid entry at level 2
        map(4, 32'h2000_0000, 2, 32'h0);
        ctx_num = 4;
        run(32'h2000_0000, 0, 0, 0, 0, 0, "R4");

        // R4: empty context entry, level 0
        ctx_num = 9;
        run(32'h3000_0000, 0, 0, 0, 0, 0, "R4");

        // R5: reserved entry at level 1
        map(5, 32'h4400_0000, 1, 32'h0000_1233);
        ctx_num = 5;
        run(32'h4400_0000, 0, 0, 0, 0, 0, "R5");

        // R5: page entry in the context table
        map(6, 32'h5000_0000, 0, pte(36'h1_0000_0000, 3, 1, 1));
        ctx_num = 6;
        run(32'h5000_0000, 0, 0, 0, 0, 0, "R5");

        // R5: descriptor at the last level
        map(7, 32'h6543_2100, 3, 32'h0000_4441);
        ctx_num = 7;
        run(32'h6543_2100, 0, 0, 0, 0, 0, "R5");

        // R5: read error at level 1
        map(8, 32'h7700_1000, 2, pte(36'h2_0000_0000, 3, 1, 1));
        err_addr = entry_addr(8, 32'h7700_1000, 1);
        ctx_num = 8;
        run(32'h7700_1000, 0, 0, 0, 0, 0, "R5");
        err_addr = '1;

        // R8: bypass boot fetch; R9: bypass data and non-boot fetch
        run(32'hABCD_1234, 0, 1, 1, 1, 0, "R8");
        run(32'hABCD_1234, 1, 0, 1, 1, 0, "R9");
        run(32'h8765_4321, 0, 1, 1, 0, 0, "R9");

        // R10 R11: request during a walk is ignored, single response
        ctx_num = 2;
        c0 = rsp_cnt;
        run(32'h0ABC_DEF0, 0, 0, 0, 0, 1, "R10");
        repeat (20) @(negedge clk);
        chk(rsp_cnt == c0 + 1, "R10", "responses", 64'(rsp_cnt - c0), 64'd1);
        chk(busy == 0, "R11", "idle_after", 64'(busy), 64'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule